// File: doc/BRIEF.md
# Light-Load Mode Selector for a Synchronous Buck Controller

This block decides whether a synchronous buck converter runs in fixed-frequency PWM or in a clock-synchronised hysteretic (pulse-frequency) mode. Once per switching cycle, at the end of low-side conduction, it receives a strobe and the sampled polarity of the switch node. A positive switch node means inductor current has reversed (light load), and a negative one means continuous conduction. A run of identical samples of a set length moves the mode one way or the other. An output-droop flag skips the run and returns the converter to PWM on the next clock.

In PWM mode the block passes an external duty request to the high side and drives the low side with its complement. In hysteretic mode it generates the high-side request itself from two feedback comparator flags. It runs the low side as a synchronous rectifier that is released as soon as reverse current is seen. After every mode change it holds both switches off for a short blanking window. A forced-PWM pin and an incomplete soft-start both keep the converter in PWM.

Top module: `pfm_mode_ctrl`

## Requirements
- R1: After reset the mode output is 0 (PWM), the blanking flag is 0 and the switch drives follow the PWM duty input.
- R2: With hysteresis allowed (forced-PWM low, soft-start done), the mode becomes 1 (hysteretic) at the clock edge that takes the DEB_CYC-th consecutive strobe with the switch-node polarity bit at 1. It does not change earlier.
- R3: In PWM mode a strobe with polarity 0 clears the positive run to zero. Cycles without a strobe neither advance nor clear the run, whatever the polarity bit shows.
- R4: In hysteretic mode the mode returns to 0 at the edge that takes the DEB_CYC-th consecutive strobe with polarity 0. A strobe with polarity 1 clears that run.
- R5: In hysteretic mode a high droop flag returns the mode to 0 at the next clock edge, with or without a strobe.
- R6: A high forced-PWM input or a low soft-start-done input blocks entry and keeps the run counter cleared. Either one, in hysteretic mode, returns the mode to 0 at the next clock edge.
- R7: In hysteretic mode the high-side drive is set one clock after the below-lower-threshold flag and cleared one clock after the above-upper-threshold flag. Otherwise it holds its state, and the PWM duty input has no effect.
- R8: In hysteretic mode the low side is on while the high-side request is off. A high reverse-current input turns it off in the same cycle, and it stays off until the next high-side request.
- R9: For BLANK_CYC clocks after each mode change the blanking flag is 1 and both drives are 0.
- R10: In PWM mode outside blanking the high-side drive equals the duty input and the low-side drive is its complement. Both drives are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_stb | input | 1 | One-clock strobe at the end of low-side conduction |
| sw_pos | input | 1 | Sampled switch-node polarity, 1 = positive |
| fb_below_lo | input | 1 | Output under the lower hysteretic threshold |
| fb_above_hi | input | 1 | Output over the upper hysteretic threshold |
| fb_droop | input | 1 | Output under the hysteretic regulation floor |
| force_pwm | input | 1 | Forbid hysteretic mode when 1 |
| ss_done | input | 1 | Soft-start has reached its completion level |
| pwm_duty | input | 1 | High-side request from the PWM comparator |
| ls_rev | input | 1 | Low-side drain-source voltage positive (reverse current) |
| mode_hyst | output | 1 | Current mode, 1 = hysteretic |
| hs_drive | output | 1 | High-side switch request |
| ls_on | output | 1 | Low-side switch request |
| both_off | output | 1 | Blanking window after a mode change |

## Verification
The bench builds the block with DEB_CYC = 4 and BLANK_CYC = 3. With these values every broken run length, from one sample to one short of the threshold and in both directions, can be swept exhaustively in a few hundred cycles. The longer blanking value tests the counter variant of the blanking timer rather than the single-flop one, and the window's last cycle can be observed at an exact edge. Each exit path from hysteretic mode (droop, forced PWM, soft-start loss, negative run) is triggered from a settled hysteretic state.

// File: rtl/pfm_mode_pkg.sv
package pfm_mode_pkg;
   typedef enum logic {
      MODE_PWM  = 1'b0,
      MODE_HYST = 1'b1
   } op_mode_e;
endpackage

// File: rtl/pol_run_cnt.sv
// Counts consecutive strobed samples that match a target polarity.
module pol_run_cnt #(
   parameter int RUN_LEN = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic stb,
   input  logic sample,
   input  logic target,
   input  logic clear,
   output logic done
);
   localparam int CW = $clog2(RUN_LEN + 1);

   logic [CW-1:0] cnt_q;
   logic          hit;
   logic          last;

   assign hit  = stb && (sample == target);
   assign last = (cnt_q == CW'(RUN_LEN - 1));
   assign done = !clear && hit && last;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clear) begin
         cnt_q <= '0;
      end else if (stb) begin
         if (!hit || last) cnt_q <= '0;
         else              cnt_q <= cnt_q + CW'(1);
      end
   end
endmodule

// File: rtl/hyst_req_gen.sv
// Hysteretic high-side request and latched low-side release.
module hyst_req_gen (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   input  logic set_lo,
   input  logic clr_hi,
   input  logic rev_det,
   output logic hs_req,
   output logic rev_hold
);
   always_ff @(posedge clk) begin
      if (!rst_n || !active) begin
         hs_req   <= 1'b0;
         rev_hold <= 1'b0;
      end else begin
         if (set_lo)      hs_req <= 1'b1;
         else if (clr_hi) hs_req <= 1'b0;
         if (hs_req)       rev_hold <= 1'b0;
         else if (rev_det) rev_hold <= 1'b1;
      end
   end
endmodule

// File: rtl/blank_timer.sv
// Holds busy for LEN clocks after a start pulse.
module blank_timer #(
   parameter int LEN = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);
   generate
      if (LEN == 1) begin : g_flop
         logic b_q;
         always_ff @(posedge clk) begin
            if (!rst_n) b_q <= 1'b0;
            else        b_q <= start;
         end
         assign busy = b_q;
      end else begin : g_count
         localparam int TW = $clog2(LEN + 1);
         logic [TW-1:0] t_q;
         always_ff @(posedge clk) begin
            if (!rst_n)         t_q <= '0;
            else if (start)     t_q <= TW'(LEN);
            else if (t_q != '0) t_q <= t_q - TW'(1);
         end
         assign busy = (t_q != '0);
      end
   endgenerate
endmodule

// File: rtl/pfm_mode_ctrl.sv
module pfm_mode_ctrl
   import pfm_mode_pkg::*;
#(
   parameter int DEB_CYC   = 8,
   parameter int BLANK_CYC = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cyc_stb,
   input  logic sw_pos,
   input  logic fb_below_lo,
   input  logic fb_above_hi,
   input  logic fb_droop,
   input  logic force_pwm,
   input  logic ss_done,
   input  logic pwm_duty,
   input  logic ls_rev,
   output logic mode_hyst,
   output logic hs_drive,
   output logic ls_on,
   output logic both_off
);
   generate
      if (DEB_CYC < 2) begin : g_bad_deb
         $error("DEB_CYC must be at least 2");
      end
      if (BLANK_CYC < 1) begin : g_bad_blank
         $error("BLANK_CYC must be at least 1");
      end
   endgenerate

   op_mode_e mode_q;
   logic     in_hyst;
   logic     allow;
   logic     run_clear;
   logic     run_done;
   logic     go_hyst;
   logic     go_pwm;
   logic     change;
   logic     hreq;
   logic     rev_hold;

   assign in_hyst   = (mode_q == MODE_HYST);
   assign allow     = !force_pwm && ss_done;
   assign run_clear = in_hyst ? (fb_droop || !allow) : !allow;

   pol_run_cnt #(.RUN_LEN(DEB_CYC)) u_run (
      .clk    (clk),
      .rst_n  (rst_n),
      .stb    (cyc_stb),
      .sample (sw_pos),
      .target (!in_hyst),
      .clear  (run_clear),
      .done   (run_done)
   );

   assign go_hyst = !in_hyst && run_done;
   assign go_pwm  = in_hyst && (run_done || fb_droop || !allow);
   assign change  = go_hyst || go_pwm;

   always_ff @(posedge clk) begin
      if (!rst_n)       mode_q <= MODE_PWM;
      else if (go_hyst) mode_q <= MODE_HYST;
      else if (go_pwm)  mode_q <= MODE_PWM;
   end

   hyst_req_gen u_req (
      .clk      (clk),
      .rst_n    (rst_n),
      .active   (in_hyst && !change),
      .set_lo   (fb_below_lo),
      .clr_hi   (fb_above_hi),
      .rev_det  (ls_rev),
      .hs_req   (hreq),
      .rev_hold (rev_hold)
   );

   blank_timer #(.LEN(BLANK_CYC)) u_blank (
      .clk   (clk),
      .rst_n (rst_n),
      .start (change),
      .busy  (both_off)
   );

   always_comb begin
      if (both_off) begin
         hs_drive = 1'b0;
         ls_on    = 1'b0;
      end else if (in_hyst) begin
         hs_drive = hreq;
         ls_on    = !hreq && !ls_rev && !rev_hold;
      end else begin
         hs_drive = pwm_duty;
         ls_on    = !pwm_duty;
      end
   end

   assign mode_hyst = in_hyst;
endmodule

// File: rtl/pfm_mode_ctrl_chk.sv
module pfm_mode_ctrl_chk (
   input logic clk,
   input logic rst_n,
   input logic fb_droop,
   input logic force_pwm,
   input logic ss_done,
   input logic pwm_duty,
   input logic ls_rev,
   input logic mode_hyst,
   input logic hs_drive,
   input logic ls_on,
   input logic both_off
);
   // R9
   mode_flip_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_hyst != $past(mode_hyst)) |-> both_off);

   // R9
   blank_drives_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      both_off |-> (!hs_drive && !ls_on));

   // R10
   no_shoot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(hs_drive && ls_on));

   // R10
   pwm_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_hyst && !both_off) |-> (hs_drive == pwm_duty));

   // R5
   droop_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_hyst && fb_droop) |=> !mode_hyst);

   // R6
   blocked_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (force_pwm || !ss_done) |=> !mode_hyst);

   // R8
   rev_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_hyst && ls_rev) |-> !ls_on);
endmodule

bind pfm_mode_ctrl pfm_mode_ctrl_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .fb_droop  (fb_droop),
   .force_pwm (force_pwm),
   .ss_done   (ss_done),
   .pwm_duty  (pwm_duty),
   .ls_rev    (ls_rev),
   .mode_hyst (mode_hyst),
   .hs_drive  (hs_drive),
   .ls_on     (ls_on),
   .both_off  (both_off)
);

// File: tb/sim_pfm_mode_ctrl.sv
`timescale 1ns/1ps
module sim_pfm_mode_ctrl;
   localparam int DEB = 4;
   localparam int BLK = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cyc_stb = 0, sw_pos = 0, fb_below_lo = 0, fb_above_hi = 0, fb_droop = 0;
   logic force_pwm = 0, ss_done = 0, pwm_duty = 0, ls_rev = 0;
   logic mode_hyst, hs_drive, ls_on, both_off;
   int   total = 0;
   int   bad = 0;

   always #5 clk = ~clk;

   pfm_mode_ctrl #(.DEB_CYC(DEB), .BLANK_CYC(BLK)) u0 (
      .clk(clk), .rst_n(rst_n), .cyc_stb(cyc_stb), .sw_pos(sw_pos),
      .fb_below_lo(fb_below_lo), .fb_above_hi(fb_above_hi), .fb_droop(fb_droop),
      .force_pwm(force_pwm), .ss_done(ss_done), .pwm_duty(pwm_duty), .ls_rev(ls_rev),
      .mode_hyst(mode_hyst), .hs_drive(hs_drive), .ls_on(ls_on), .both_off(both_off)
   );

   task automatic chk(input string tag, input logic act, input logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%0b exp=%0b", tag, act, exp);
      end
   endtask

   task automatic strobe(input logic p);
      sw_pos  = p;
      cyc_stb = 1'b1;
      @(negedge clk);
      cyc_stb = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic enter_hyst();
      repeat (DEB) strobe(1'b1);
      idle(BLK);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      pwm_duty = 1'b1;
      #1;
      chk("R1 mode after reset", mode_hyst, 1'b0);
      chk("R1 blank after reset", both_off, 1'b0);
      chk("R1 hs follows duty", hs_drive, 1'b1);
      chk("R10 ls complement", ls_on, 1'b0);
      pwm_duty = 1'b0;
      #1;
      chk("R10 hs duty low", hs_drive, 1'b0);
      chk("R10 ls on", ls_on, 1'b1);
      @(negedge clk);

      // R6: soft-start pending, then forced PWM, both block entry
      repeat (DEB + 2) strobe(1'b1);
      chk("R6 no entry before soft-start", mode_hyst, 1'b0);
      ss_done = 1'b1;
      force_pwm = 1'b1;
      repeat (DEB + 2) strobe(1'b1);
      chk("R6 no entry with forced PWM", mode_hyst, 1'b0);
      force_pwm = 1'b0;
      repeat (DEB - 1) strobe(1'b1);
      chk("R6 run was held clear", mode_hyst, 1'b0);
      strobe(1'b0);

      // R3: every broken run length, with unstrobed noise in between
      for (int n = 1; n < DEB; n++) begin
         repeat (n) begin
            strobe(1'b1);
            sw_pos = 1'b0;
            idle(2);
         end
         strobe(1'b0);
         chk($sformatf("R3 broken run %0d", n), mode_hyst, 1'b0);
         repeat (DEB - 1) strobe(1'b1);
         chk($sformatf("R3 run restarted after %0d", n), mode_hyst, 1'b0);
         strobe(1'b0);
      end

      // R2 / R9: entry at exactly the DEB-th positive strobe
      pwm_duty = 1'b1;
      repeat (DEB - 1) strobe(1'b1);
      chk("R2 not yet hysteretic", mode_hyst, 1'b0);
      strobe(1'b1);
      chk("R2 hysteretic at threshold", mode_hyst, 1'b1);
      chk("R9 blank on entry", both_off, 1'b1);
      chk("R9 hs off in blank", hs_drive, 1'b0);
      chk("R9 ls off in blank", ls_on, 1'b0);
      idle(BLK - 1);
      chk("R9 blank last cycle", both_off, 1'b1);
      idle(1);
      chk("R9 blank ended", both_off, 1'b0);
      chk("R8 ls on without request", ls_on, 1'b1);
      chk("R7 duty ignored in hysteretic", hs_drive, 1'b0);

      // R7: hysteretic request
      fb_below_lo = 1'b1;
      @(negedge clk);
      fb_below_lo = 1'b0;
      chk("R7 request set", hs_drive, 1'b1);
      chk("R8 ls off with request", ls_on, 1'b0);
      pwm_duty = 1'b0;
      idle(2);
      chk("R7 request holds", hs_drive, 1'b1);
      fb_above_hi = 1'b1;
      @(negedge clk);
      fb_above_hi = 1'b0;
      chk("R7 request cleared", hs_drive, 1'b0);
      chk("R8 ls back on", ls_on, 1'b1);

      // R8: reverse-current release
      ls_rev = 1'b1;
      #1;
      chk("R8 immediate release", ls_on, 1'b0);
      @(negedge clk);
      ls_rev = 1'b0;
      #1;
      chk("R8 release held", ls_on, 1'b0);
      idle(2);
      chk("R8 release still held", ls_on, 1'b0);
      fb_below_lo = 1'b1;
      @(negedge clk);
      fb_below_lo = 1'b0;
      idle(2);
      fb_above_hi = 1'b1;
      @(negedge clk);
      fb_above_hi = 1'b0;
      chk("R8 release cleared by request", ls_on, 1'b1);

      // R4: broken negative runs keep hysteretic mode
      for (int n = 1; n < DEB; n++) begin
         repeat (n) strobe(1'b0);
         strobe(1'b1);
         chk($sformatf("R4 broken negative run %0d", n), mode_hyst, 1'b1);
      end
      repeat (DEB - 1) strobe(1'b0);
      chk("R4 not yet PWM", mode_hyst, 1'b1);
      strobe(1'b0);
      chk("R4 back to PWM", mode_hyst, 1'b0);
      chk("R9 blank on exit", both_off, 1'b1);
      idle(BLK);
      chk("R9 blank ended after exit", both_off, 1'b0);

      // R5: droop exit without a strobe
      enter_hyst();
      chk("R5 setup hysteretic", mode_hyst, 1'b1);
      fb_droop = 1'b1;
      @(negedge clk);
      fb_droop = 1'b0;
      chk("R5 droop exit next clock", mode_hyst, 1'b0);
      chk("R9 blank on droop exit", both_off, 1'b1);
      idle(BLK);

      // R6: forced PWM and soft-start loss exit hysteretic mode
      enter_hyst();
      force_pwm = 1'b1;
      @(negedge clk);
      force_pwm = 1'b0;
      chk("R6 forced exit next clock", mode_hyst, 1'b0);
      idle(BLK);
      enter_hyst();
      ss_done = 1'b0;
      @(negedge clk);
      chk("R6 soft-start exit next clock", mode_hyst, 1'b0);
      pwm_duty = 1'b1;
      idle(BLK);
      chk("R10 duty after exit", hs_drive, 1'b1);
      chk("R10 ls after exit", ls_on, 1'b0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule